// File: doc/BRIEF.md
# Four-Way Translation Buffer with Refill Way Hint

This block holds sixteen entries in each of four ways and translates a 32-bit virtual address to a physical address with 8 KiB pages. A lookup takes the virtual page number, the current process identifier, a user-mode flag and configuration bits. It reads the entry at the page's index in all four ways and compares each one. The result is registered and appears one clock after the request. It is a translation, a miss, or a kernel-protection fault.

When a lookup faults, the block offers refill software a hint for where to put the replacement entry. The hint pairs the page index with a way drawn from an internal 16-bit linear feedback shift register. That register steps once per fault and holds still otherwise. Software loads entries through a write port that takes an entry's two 32-bit words. When translation is switched off in the configuration, addresses pass through unchanged.

Top module: `tlb4_xlate`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears every entry to zero, drives rsp_valid, rsp_ok, rsp_miss, rsp_kfault and rsp_paddr to zero, sets refill_sel to zero and loads the hint register with 0xCCCC.
- R2: A write (wr_en high) stores the entry at way wr_way, index wr_idx. From wr_hi it keeps the page number (bits 31..13) and the process tag (bits 7..0). From wr_lo it keeps the frame number (bits 31..13), the global flag (bit 4) and the kernel flag (bit 2). The other bits have no effect on lookups.
- R3: An entry matches when its page number equals req_vaddr[31:13] and either its global flag is set or its process tag equals req_pid. A tag mismatch on a non-global entry counts as a miss.
- R4: A request with req_valid high at an edge produces rsp_valid high after that edge, with exactly one of rsp_ok, rsp_miss or rsp_kfault set. On a translated hit, rsp_paddr is the matched frame number joined with req_vaddr[12:0].
- R5: When a match is found, kprot_en is high, the entry's kernel flag is set and req_user is high, the result is rsp_kfault with rsp_paddr zero. If any one of the three is clear, the result is rsp_ok.
- R6: Translation is on only when glb_cfg[2] or glb_cfg[3] is set. Otherwise the result is rsp_ok with rsp_paddr equal to req_vaddr. Such a lookup does not step the hint register and leaves refill_sel unchanged.
- R7: Each fault (a miss or a kernel-protection fault) steps the hint register once. The register shifts right by one bit, and the new bit 15 is the parity of the old value ANDed with 0x8805.
- R8: On a fault, refill_sel[3:0] becomes the index req_vaddr[16:13] and refill_sel[5:4] becomes bits 1..0 of the hint register as they were before that fault's step. refill_sel keeps its value across lookups that do not fault.
- R9: If several ways match, the result comes from the lowest-numbered matching way.
- R10: When a write and a lookup happen at the same edge, the lookup sees the entry contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| glb_cfg | input | 4 | Global configuration; bit 2 or bit 3 turns translation on |
| kprot_en | input | 1 | Enables kernel-page protection against user accesses |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Way written |
| wr_idx | input | 4 | Index written |
| wr_hi | input | 32 | Entry high word: page number, process tag |
| wr_lo | input | 32 | Entry low word: frame number, global, kernel flags |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_pid | input | 8 | Current process identifier |
| req_user | input | 1 | Access made in user mode |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_ok | output | 1 | Translation (or pass-through) succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_kfault | output | 1 | Kernel-protection fault |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| refill_sel | output | 6 | Refill hint: way in 5..4, index in 3..0 |

## Verification
A wrong hint register stays hidden until the next fault. Then it shows up in refill_sel[5:4] one clock after that lookup, and once the register has gone wrong, every later hint follows the wrong sequence. The bench therefore follows the register through chains of misses, kernel faults, hits and pass-through lookups. A corrupted entry or a bad match priority shows in rsp_paddr or the result flags on the very next lookup to that index. Write-versus-lookup ordering is checked by a write and a lookup at the same edge followed by a second lookup.

// File: rtl/tlb4_pkg.sv
// tlb4_pkg: shared widths, field positions and entry type for the
// four-way translation buffer. Assumes 32-bit addresses, 8 KiB pages.
package tlb4_pkg;
    parameter int unsigned VA_W      = 32;
    parameter int unsigned PAGE_OFS  = 13;
    parameter int unsigned VPN_W     = VA_W - PAGE_OFS;
    parameter int unsigned PID_W     = 8;
    parameter int unsigned NUM_WAYS  = 4;
    parameter int unsigned IDX_W     = 4;
    parameter int unsigned DEPTH     = 1 << IDX_W;
    parameter int unsigned WAY_W     = $clog2(NUM_WAYS);
    parameter int unsigned SEL_W     = IDX_W + WAY_W;
    parameter int unsigned HINT_W    = 16;
    parameter logic [HINT_W-1:0] HINT_SEED = 16'hCCCC;
    parameter logic [HINT_W-1:0] HINT_TAPS = 16'h8805;

    // Low-word flag positions that the decode depends on
    parameter int unsigned LO_GLOBAL_BIT = 4;
    parameter int unsigned LO_KERNEL_BIT = 2;

    // Decoded entry as held in storage
    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PID_W-1:0] tag;
        logic [VPN_W-1:0] pfn;
        logic             glob;
        logic             kern;
    } tlb_entry_t;

    // Registered outcome class of a lookup
    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_OK     = 2'd1,
        OUT_MISS   = 2'd2,
        OUT_KFAULT = 2'd3
    } lookup_out_t;
endpackage

// File: rtl/tlb4_way_bank.sv
// tlb4_way_bank: one way of the buffer. Decodes the two entry words at
// write time and keeps only the fields lookups use. The read is
// combinational, so a lookup in the cycle of a write sees old data.
// Assumes the caller gates wr_en per way.
module tlb4_way_bank
    import tlb4_pkg::*;
#(
    parameter int unsigned BANK_DEPTH = DEPTH,
    parameter int unsigned BANK_AW    = $clog2(BANK_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BANK_AW-1:0] wr_addr,
    input  logic [VA_W-1:0]    wr_hi,
    input  logic [VA_W-1:0]    wr_lo,
    input  logic [BANK_AW-1:0] rd_addr,
    output tlb_entry_t         rd_ent
);
    tlb_entry_t mem [BANK_DEPTH];
    tlb_entry_t wr_ent;

    // Field bits with no meaning for lookups
    logic unused_fields;
    assign unused_fields = ^{wr_hi[PAGE_OFS-1:PID_W], wr_lo[PAGE_OFS-1:LO_GLOBAL_BIT+1],
                             wr_lo[LO_GLOBAL_BIT-1], wr_lo[LO_KERNEL_BIT-1:0]};

    // Split the incoming words into the stored entry fields
    always_comb begin
        wr_ent.vpn  = wr_hi[VA_W-1:PAGE_OFS];
        wr_ent.tag  = wr_hi[PID_W-1:0];
        wr_ent.pfn  = wr_lo[VA_W-1:PAGE_OFS];
        wr_ent.glob = wr_lo[LO_GLOBAL_BIT];
        wr_ent.kern = wr_lo[LO_KERNEL_BIT];
    end

    // Entry storage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(BANK_DEPTH); i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_ent;
        end
    end

    // Combinational read port
    assign rd_ent = mem[rd_addr];

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)].pfn == $past(wr_lo[VA_W-1:PAGE_OFS])
                   && mem[$past(wr_addr)].vpn == $past(wr_hi[VA_W-1:PAGE_OFS]))); // R2
endmodule

// File: rtl/tlb4_hit_select.sv
// tlb4_hit_select: compares the indexed entry of every way against the
// request and picks the lowest-numbered matching way. Purely
// combinational; clk and rst_n serve only the local assertions.
module tlb4_hit_select
    import tlb4_pkg::*;
#(
    parameter int unsigned NW = NUM_WAYS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  tlb_entry_t [NW-1:0]    ents,
    input  logic [VPN_W-1:0]       req_vpn,
    input  logic [PID_W-1:0]       req_pid,
    output logic                   hit,
    output logic [VPN_W-1:0]       hit_pfn,
    output logic                   hit_kern
);
    logic [NW-1:0] match_vec;
    logic [NW-1:0] pick_vec;

    // Per-way tag compare: page equal and (global or tag equal)
    for (genvar w = 0; w < int'(NW); w++) begin : g_cmp
        assign match_vec[w] = (ents[w].vpn == req_vpn)
                              && (ents[w].glob || (ents[w].tag == req_pid));
    end

    // Priority pick: scan from the top so the lowest way lands last
    always_comb begin
        pick_vec = '0;
        hit_pfn  = '0;
        hit_kern = 1'b0;
        for (int w = int'(NW) - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                pick_vec = '0;
                pick_vec[w] = 1'b1;
                hit_pfn  = ents[w].pfn;
                hit_kern = ents[w].kern;
            end
        end
    end

    assign hit = |match_vec;

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_vec) && ((|pick_vec) == hit)); // R9
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec & (pick_vec - 1'b1)) == '0)); // R9
endmodule

// File: rtl/tlb4_hint_lfsr.sv
// tlb4_hint_lfsr: 16-bit right-shifting feedback register that supplies
// the refill way hint. Steps only when adv is high; the new top bit is
// the parity of the state masked by the tap pattern.
module tlb4_hint_lfsr
    import tlb4_pkg::*;
#(
    parameter int unsigned         W    = HINT_W,
    parameter logic [HINT_W-1:0]   SEED = HINT_SEED,
    parameter logic [HINT_W-1:0]   TAPS = HINT_TAPS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);
    logic fb;

    // Feedback bit from masked parity
    assign fb = ^(state & TAPS[W-1:0]);

    // State register: seed on reset, shift right on each fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED[W-1:0];
        end else if (adv) begin
            state <= {fb, state[W-1:1]};
        end
    end

    AST_HINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state)); // R7
    AST_HINT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (state[W-2:0] == $past(state[W-1:1]))); // R7
endmodule

// File: rtl/tlb4_xlate.sv
// tlb4_xlate: four-way, sixteen-index translation buffer with a
// pseudo-random refill way hint. Lookups are read in the request cycle
// and answered one clock later. Assumes software keeps the process tag
// in req_pid and loads entries through the write port.
module tlb4_xlate
    import tlb4_pkg::*;
#(
    parameter logic [HINT_W-1:0] SEED = HINT_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        glb_cfg,
    input  logic              kprot_en,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_hi,
    input  logic [VA_W-1:0]   wr_lo,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PID_W-1:0]  req_pid,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_miss,
    output logic              rsp_kfault,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [SEL_W-1:0]  refill_sel
);
    logic [VPN_W-1:0]          req_vpn;
    logic [IDX_W-1:0]          req_idx;
    logic                      xlate_on;
    tlb_entry_t [NUM_WAYS-1:0] way_ent;
    logic                      any_hit;
    logic [VPN_W-1:0]          sel_pfn;
    logic                      sel_kern;
    logic                      kfault_c;
    logic                      fault_c;
    lookup_out_t               out_c;
    logic [VA_W-1:0]           paddr_c;
    logic [HINT_W-1:0]         hint_q;

    // Request field split and translation enable
    assign req_vpn  = req_vaddr[VA_W-1:PAGE_OFS];
    assign req_idx  = req_vpn[IDX_W-1:0];
    assign xlate_on = glb_cfg[2] | glb_cfg[3];

    // One storage bank per way, write strobe gated by way number
    for (genvar w = 0; w < int'(NUM_WAYS); w++) begin : g_way
        tlb4_way_bank #(.BANK_DEPTH(DEPTH)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_way == WAY_W'(w))),
            .wr_addr (wr_idx),
            .wr_hi   (wr_hi),
            .wr_lo   (wr_lo),
            .rd_addr (req_idx),
            .rd_ent  (way_ent[w])
        );
    end

    tlb4_hit_select #(.NW(NUM_WAYS)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ents     (way_ent),
        .req_vpn  (req_vpn),
        .req_pid  (req_pid),
        .hit      (any_hit),
        .hit_pfn  (sel_pfn),
        .hit_kern (sel_kern)
    );

    tlb4_hint_lfsr #(.W(HINT_W), .SEED(SEED), .TAPS(HINT_TAPS)) u_hint (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fault_c),
        .state (hint_q)
    );

    // Classify the lookup and form the physical address
    always_comb begin
        kfault_c = any_hit && kprot_en && sel_kern && req_user;
        out_c    = OUT_NONE;
        paddr_c  = '0;
        if (req_valid) begin
            if (!xlate_on) begin
                out_c   = OUT_OK;
                paddr_c = req_vaddr;
            end else if (!any_hit) begin
                out_c   = OUT_MISS;
            end else if (kfault_c) begin
                out_c   = OUT_KFAULT;
            end else begin
                out_c   = OUT_OK;
                paddr_c = {sel_pfn, req_vaddr[PAGE_OFS-1:0]};
            end
        end
        fault_c = (out_c == OUT_MISS) || (out_c == OUT_KFAULT);
    end

    // Result register, one clock after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_ok     <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_kfault <= 1'b0;
            rsp_paddr  <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_ok     <= (out_c == OUT_OK);
            rsp_miss   <= (out_c == OUT_MISS);
            rsp_kfault <= (out_c == OUT_KFAULT);
            rsp_paddr  <= paddr_c;
        end
    end

    // Refill hint register: replaced whole on a fault, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refill_sel <= '0;
        end else if (fault_c) begin
            refill_sel <= {hint_q[WAY_W-1:0], req_idx};
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_ok, rsp_miss, rsp_kfault}) == 1)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_ok || rsp_miss || rsp_kfault)); // R4
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlate_on) |=> (rsp_ok && rsp_paddr == $past(req_vaddr))); // R6
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlate_on) |=> (rsp_ok -> rsp_paddr[PAGE_OFS-1:0] == $past(req_vaddr[PAGE_OFS-1:0]))); // R4
    AST_KFAULT_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_user && kprot_en)) |=> !rsp_kfault); // R5
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_c |=> $stable(refill_sel)); // R8
    AST_SEL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        fault_c |=> (refill_sel[IDX_W-1:0] == $past(req_vaddr[PAGE_OFS+IDX_W-1:PAGE_OFS]))); // R8
endmodule

// File: tb/sim_tlb4_xlate.sv
// Directed bench for tlb4_xlate: one task per scenario, each checking
// its own results against values derived from the requirements.
module sim_tlb4_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  glb_cfg = '0;
    logic        kprot_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_way = '0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_hi = '0;
    logic [31:0] wr_lo = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_pid = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid, rsp_ok, rsp_miss, rsp_kfault;
    logic [31:0] rsp_paddr;
    logic [5:0]  refill_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [15:0] m_hint = 16'hCCCC;   // bench model of the hint register
    logic [5:0]  m_sel = '0;

    always #2 clk = ~clk;   // 250 MHz

    tlb4_xlate u0 (
        .clk(clk), .rst_n(rst_n), .glb_cfg(glb_cfg), .kprot_en(kprot_en),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_pid(req_pid), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_miss(rsp_miss), .rsp_kfault(rsp_kfault),
        .rsp_paddr(rsp_paddr), .refill_sel(refill_sel)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Hint step from R7: shift right, top bit = parity(state & 0x8805)
    function automatic logic [15:0] hint_step(input logic [15:0] s);
        logic p = 1'b0;
        logic [15:0] taps = 16'h8805;
        for (int i = 0; i < 16; i++) p = p ^ (s[i] & taps[i]);
        return {p, s[15:1]};
    endfunction

    function automatic logic [31:0] mk_hi(input logic [18:0] vpn, input logic [7:0] tag);
        return {vpn, 5'b0, tag};
    endfunction

    function automatic logic [31:0] mk_lo(input logic [18:0] pfn, input logic g, input logic k);
        return {pfn, 8'b0, g, 1'b1, k, 1'b1, 1'b0};
    endfunction

    task automatic write_entry(input logic [1:0] way, input logic [3:0] idx,
                               input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        wr_en = 1'b1; wr_way = way; wr_idx = idx; wr_hi = hi; wr_lo = lo;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one lookup; results are sampled at the following negedge
    task automatic lookup(input logic [31:0] va, input logic [7:0] pid, input logic user);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_pid = pid; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // kind: 0 ok, 1 miss, 2 kernel fault
    task automatic expect_rsp(input string req, input int kind, input logic [31:0] pa);
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " ok"}, 32'(rsp_ok), 32'(kind == 0));
        check({req, " miss"}, 32'(rsp_miss), 32'(kind == 1));
        check({req, " kfault"}, 32'(rsp_kfault), 32'(kind == 2));
        check({req, " paddr"}, rsp_paddr, (kind == 0) ? pa : 32'h0);
        if (kind != 0) begin
            m_sel  = {m_hint[1:0], req_vaddr[16:13]};
            m_hint = hint_step(m_hint);
        end
        check({req, " refill_sel"}, 32'(refill_sel), 32'(m_sel));
    endtask

    task automatic t_reset();
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 refill_sel", 32'(refill_sel), 32'd0);
        check("R1 rsp_paddr", rsp_paddr, 32'd0);
    endtask

    task automatic t_bypass();
        glb_cfg = 4'b0011;   // R6: bits 0/1 alone leave translation off
        lookup(32'h1234_5678, 8'h01, 1'b1);
        expect_rsp("R6 bypass cfg=3", 0, 32'h1234_5678);
        glb_cfg = 4'b0000;
        lookup(32'hFEDC_BA98, 8'h02, 1'b0);
        expect_rsp("R6 bypass cfg=0", 0, 32'hFEDC_BA98);
        @(negedge clk);
        check("R4 valid drops", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_hit_and_pid();
        glb_cfg = 4'b0100;
        write_entry(2'd2, 4'h5, mk_hi(19'h002A5, 8'h3A), mk_lo(19'h12345, 1'b0, 1'b0));
        lookup({19'h002A5, 13'h0ABC}, 8'h3A, 1'b1);
        expect_rsp("R2 R3 R4 hit", 0, {19'h12345, 13'h0ABC});
        lookup({19'h002A5, 13'h0ABC}, 8'h3B, 1'b1);
        expect_rsp("R3 pid mismatch miss R8 first hint way", 1, 32'h0);
    endtask

    task automatic t_global();
        write_entry(2'd0, 4'h9, mk_hi(19'h70009, 8'h11), mk_lo(19'h00F0F, 1'b1, 1'b0));
        lookup({19'h70009, 13'h1FFF}, 8'hEE, 1'b0);
        expect_rsp("R3 global ignores tag", 0, {19'h00F0F, 13'h1FFF});
    endtask

    task automatic t_kernel();
        write_entry(2'd3, 4'hC, mk_hi(19'h0123C, 8'h22), mk_lo(19'h55555, 1'b0, 1'b1));
        kprot_en = 1'b1;
        lookup({19'h0123C, 13'h0004}, 8'h22, 1'b1);
        expect_rsp("R5 kernel fault R7 step", 2, 32'h0);
        lookup({19'h0123C, 13'h0004}, 8'h22, 1'b0);
        expect_rsp("R5 supervisor ok", 0, {19'h55555, 13'h0004});
        kprot_en = 1'b0;
        lookup({19'h0123C, 13'h0008}, 8'h22, 1'b1);
        expect_rsp("R5 protect off ok", 0, {19'h55555, 13'h0008});
        glb_cfg = 4'b1000;
        lookup({19'h0123C, 13'h0010}, 8'h22, 1'b0);
        expect_rsp("R6 cfg bit3 translates", 0, {19'h55555, 13'h0010});
        glb_cfg = 4'b0100;
    endtask

    task automatic t_miss_chain();
        for (int i = 0; i < 6; i++) begin
            lookup({19'h40000 + 19'(i * 17), 13'h0}, 8'h00, 1'b0);
            expect_rsp("R7 R8 miss chain", 1, 32'h0);
        end
    endtask

    task automatic t_sel_hold();
        lookup({19'h002A5, 13'h0}, 8'h3A, 1'b0);
        expect_rsp("R8 hold on hit", 0, {19'h12345, 13'h0});
        glb_cfg = 4'b0000;
        lookup({19'h4444B, 13'h0}, 8'h00, 1'b0);
        expect_rsp("R6 bypass keeps hint", 0, {19'h4444B, 13'h0});
        glb_cfg = 4'b0100;
        lookup({19'h4444B, 13'h0}, 8'h00, 1'b0);
        expect_rsp("R6 R7 no step during bypass", 1, 32'h0);
    endtask

    task automatic t_multi();
        write_entry(2'd3, 4'h7, mk_hi(19'h33337, 8'h05), mk_lo(19'h0BBBB, 1'b0, 1'b0));
        write_entry(2'd1, 4'h7, mk_hi(19'h33337, 8'h05), mk_lo(19'h0AAAA, 1'b0, 1'b0));
        lookup({19'h33337, 13'h0123}, 8'h05, 1'b0);
        expect_rsp("R9 lowest way wins", 0, {19'h0AAAA, 13'h0123});
    endtask

    task automatic t_collide();
        @(negedge clk);
        wr_en = 1'b1; wr_way = 2'd1; wr_idx = 4'h7;
        wr_hi = mk_hi(19'h33337, 8'h05); wr_lo = mk_lo(19'h0CCCC, 1'b0, 1'b0);
        req_valid = 1'b1; req_vaddr = {19'h33337, 13'h0042}; req_pid = 8'h05; req_user = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        expect_rsp("R10 old data in write cycle", 0, {19'h0AAAA, 13'h0042});
        lookup({19'h33337, 13'h0042}, 8'h05, 1'b0);
        expect_rsp("R10 R2 new data after write", 0, {19'h0CCCC, 13'h0042});
    endtask

    // Watchdog: an expiry counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_bypass();
        t_hit_and_pid();
        t_global();
        t_kernel();
        t_miss_chain();
        t_sel_hold();
        t_multi();
        t_collide();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule